// File: doc/BRIEF.md
# Multi-Page DMA Burst Mover

This block carries out a single data DMA command that has already been dispatched to it. The command names a direction, a host memory pointer and a number of flash pages. The block moves all of those pages between a word stream on the flash side and system memory. The memory side is a simple burst master with a request channel, a write-data channel and a read-data channel, each using a valid/ready handshake.

The transfer is cut into bursts. Their size in words comes from a configuration input, which is sampled once when the command is accepted. Host addresses run linearly from the command's pointer. The block never splits a burst at a 4 KB address line. Choosing a start address that keeps bursts inside such a window is the caller's job.

Exactly one done pulse marks the end of each command. After that pulse the mover is idle again and can take the next queued command.

Top module: `pgdma_mover`

## Requirements
- R1: An accepted command moves exactly `cmd_pages * PAGE_WORDS` data words. `xfer_done` is then high for exactly one cycle, in the cycle after the handshake of the final data word.
- R2: The burst size is `cfg_burst_len` as sampled in the accept cycle, with the value 0 treated as 1. Each burst requests min(burst size, words still to move). Changes to `cfg_burst_len` during a transfer have no effect on that transfer.
- R3: The first request carries `cmd_host_addr`. Each later request carries the previous address plus the previous length times `DATA_W/8` bytes. A burst that crosses a 4 KB address line is still issued as one request.
- R4: With `cmd_to_flash` = 0, every request has `mem_req_rnw` = 0 and the words of `fin_data` appear on `mem_wdata` in arrival order. With `cmd_to_flash` = 1, every request has `mem_req_rnw` = 1 and the words of `mem_rdata` appear on `fout_data` in arrival order. The channels of the other direction stay idle.
- R5: Deasserting any of the ready or valid inputs stalls the transfer without dropping or repeating a word. A request that is not yet accepted keeps its address and length unchanged.
- R6: `cmd_ready` is high only while the mover is idle. A command presented while a transfer is in progress is not taken and causes no traffic and no extra done pulse.
- R7: A command with a page count of 0 issues no memory request. It raises `xfer_done` in the cycle after acceptance.
- R8: While reset is applied, and in the cycle after it, `cmd_ready` = 1 and `mem_req_valid` = 0 and `xfer_done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | BLEN_W | Burst size in words (0 means 1) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Mover idle, command can be taken |
| cmd_to_flash | input | 1 | 1: memory to flash, 0: flash to memory |
| cmd_host_addr | input | ADDR_W | Host byte address of the first word |
| cmd_pages | input | PCNT_W | Number of pages to move |
| mem_req_valid | output | 1 | Burst request valid |
| mem_req_ready | input | 1 | Burst request accepted |
| mem_req_rnw | output | 1 | 1: memory read burst, 0: memory write burst |
| mem_req_addr | output | ADDR_W | Burst start byte address |
| mem_req_len | output | BLEN_W | Burst length in words |
| mem_wdata_valid | output | 1 | Write word valid |
| mem_wdata_ready | input | 1 | Write word accepted |
| mem_wdata | output | DATA_W | Write word |
| mem_rdata_valid | input | 1 | Read word valid |
| mem_rdata_ready | output | 1 | Read word accepted |
| mem_rdata | input | DATA_W | Read word |
| fin_valid | input | 1 | Flash-side source word valid |
| fin_ready | output | 1 | Flash-side source word taken |
| fin_data | input | DATA_W | Flash-side source word |
| fout_valid | output | 1 | Flash-side sink word valid |
| fout_ready | input | 1 | Flash-side sink word taken |
| fout_data | output | DATA_W | Flash-side sink word |
| xfer_done | output | 1 | One-cycle pulse at command completion |

## Verification
The closest overlap is a new command arriving in the same cycle that the mover finishes the previous one. The done pulse and an offered `cmd_valid` land on the same clock, and the command must still wait for idle. The bench provokes this by holding `cmd_valid` high with random fields for the whole transfer, changing `cfg_burst_len` as well, and lowering it only once done is seen. A correct result has exactly one done pulse, a burst list that matches the original command, and done timed one cycle after the last word. A second overlap is the final data word of a burst, which also retires the address and count. Random stalls on every handshake move that word onto many different cycles, and the resulting address list is compared with a list the bench computes itself.

// File: rtl/pgdma_pkg.sv
`timescale 1ns/1ps
package pgdma_pkg;

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_REQ  = 2'd1,
        MV_DATA = 2'd2,
        MV_FIN  = 2'd3
    } mv_state_e;

    typedef enum logic {
        DIR_TO_HOST  = 1'b0,
        DIR_TO_FLASH = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        xfer_dir_e dir;
        logic      no_pages;
    } cmd_flags_t;

    function automatic int unsigned byte_shift(int unsigned data_w);
        return $clog2(data_w / 8);
    endfunction

    function automatic int unsigned wider(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pgdma_planner.sv
`timescale 1ns/1ps
module pgdma_planner #(
    parameter int ADDR_W  = 32,
    parameter int TW_W    = 13,
    parameter int BLEN_W  = 8,
    parameter int BYTE_SH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [TW_W-1:0]   ld_total,
    input  logic [BLEN_W-1:0] ld_blen,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BLEN_W-1:0] cur_len,
    output logic              final_burst
);
    localparam int CW = pgdma_pkg::wider(TW_W, BLEN_W);

    logic [ADDR_W-1:0] addr_q;
    logic [TW_W-1:0]   rem_q;
    logic [BLEN_W-1:0] blen_q;
    logic              short_tail;

    always_comb begin
        short_tail  = CW'(rem_q) < CW'(blen_q);
        cur_len     = short_tail ? BLEN_W'(rem_q) : blen_q;
        final_burst = CW'(rem_q) <= CW'(blen_q);
        cur_addr    = addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rem_q  <= '0;
            blen_q <= BLEN_W'(1);
        end else if (load) begin
            addr_q <= ld_addr;
            rem_q  <= ld_total;
            blen_q <= ld_blen;
        end else if (advance) begin
            addr_q <= addr_q + (ADDR_W'(cur_len) << BYTE_SH);
            rem_q  <= rem_q - TW_W'(cur_len);
        end
    end
endmodule

// File: rtl/pgdma_beat_ctr.sv
`timescale 1ns/1ps
module pgdma_beat_ctr #(
    parameter int BLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BLEN_W-1:0] ld_len,
    input  logic              beat,
    output logic              last
);
    logic [BLEN_W-1:0] left_q;

    assign last = (left_q == BLEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= ld_len;
        end else if (beat && left_q != '0) begin
            left_q <= left_q - BLEN_W'(1);
        end
    end
endmodule

// File: rtl/pgdma_steer.sv
`timescale 1ns/1ps
module pgdma_steer
    import pgdma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              in_data,
    input  xfer_dir_e         dir,
    input  logic              fin_valid,
    output logic              fin_ready,
    input  logic [DATA_W-1:0] fin_data,
    output logic              mem_wdata_valid,
    input  logic              mem_wdata_ready,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rdata_valid,
    output logic              mem_rdata_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fout_valid,
    input  logic              fout_ready,
    output logic [DATA_W-1:0] fout_data,
    output logic              beat
);
    logic to_host;
    logic to_flash;

    always_comb begin
        to_host         = in_data && (dir == DIR_TO_HOST);
        to_flash        = in_data && (dir == DIR_TO_FLASH);
        mem_wdata_valid = to_host && fin_valid;
        fin_ready       = to_host && mem_wdata_ready;
        mem_wdata       = fin_data;
        fout_valid      = to_flash && mem_rdata_valid;
        mem_rdata_ready = to_flash && fout_ready;
        fout_data       = mem_rdata;
        beat            = (to_host && fin_valid && mem_wdata_ready) ||
                          (to_flash && mem_rdata_valid && fout_ready);
    end
endmodule

// File: rtl/pgdma_mover.sv
`timescale 1ns/1ps
module pgdma_mover
    import pgdma_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int PAGE_WORDS = 16,
    parameter int PCNT_W     = 8,
    parameter int BLEN_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BLEN_W-1:0] cfg_burst_len,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_to_flash,
    input  logic [ADDR_W-1:0] cmd_host_addr,
    input  logic [PCNT_W-1:0] cmd_pages,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_rnw,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [BLEN_W-1:0] mem_req_len,
    output logic              mem_wdata_valid,
    input  logic              mem_wdata_ready,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rdata_valid,
    output logic              mem_rdata_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              fin_valid,
    output logic              fin_ready,
    input  logic [DATA_W-1:0] fin_data,
    output logic              fout_valid,
    input  logic              fout_ready,
    output logic [DATA_W-1:0] fout_data,
    output logic              xfer_done
);
    localparam int TW_W    = PCNT_W + $clog2(PAGE_WORDS) + 1;
    localparam int BYTE_SH = byte_shift(DATA_W);

    mv_state_e         state_q, state_d;
    xfer_dir_e         dir_q;
    cmd_flags_t        new_cmd;
    logic              accept;
    logic              req_fire;
    logic              beat;
    logic              beat_last;
    logic              final_burst;
    logic              burst_end;
    logic [TW_W-1:0]   total_words;
    logic [BLEN_W-1:0] eff_blen;
    logic [ADDR_W-1:0] plan_addr;
    logic [BLEN_W-1:0] plan_len;

    always_comb begin
        new_cmd.dir      = cmd_to_flash ? DIR_TO_FLASH : DIR_TO_HOST;
        new_cmd.no_pages = (cmd_pages == '0);
        total_words      = TW_W'(cmd_pages) * TW_W'(PAGE_WORDS);
        eff_blen         = (cfg_burst_len == '0) ? BLEN_W'(1) : cfg_burst_len;
        cmd_ready        = (state_q == MV_IDLE);
        accept           = cmd_ready && cmd_valid;
        mem_req_valid    = (state_q == MV_REQ);
        req_fire         = mem_req_valid && mem_req_ready;
        mem_req_addr     = plan_addr;
        mem_req_len      = plan_len;
        mem_req_rnw      = (dir_q == DIR_TO_FLASH);
        burst_end        = (state_q == MV_DATA) && beat && beat_last;
        xfer_done        = (state_q == MV_FIN);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MV_IDLE: if (accept)   state_d = new_cmd.no_pages ? MV_FIN : MV_REQ;
            MV_REQ:  if (req_fire) state_d = MV_DATA;
            MV_DATA: if (burst_end) state_d = final_burst ? MV_FIN : MV_REQ;
            MV_FIN:  state_d = MV_IDLE;
            default: state_d = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MV_IDLE;
            dir_q   <= DIR_TO_HOST;
        end else begin
            state_q <= state_d;
            if (accept) dir_q <= new_cmd.dir;
        end
    end

    pgdma_planner #(
        .ADDR_W (ADDR_W),
        .TW_W   (TW_W),
        .BLEN_W (BLEN_W),
        .BYTE_SH(BYTE_SH)
    ) u_plan (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .ld_addr    (cmd_host_addr),
        .ld_total   (total_words),
        .ld_blen    (eff_blen),
        .advance    (burst_end),
        .cur_addr   (plan_addr),
        .cur_len    (plan_len),
        .final_burst(final_burst)
    );

    pgdma_beat_ctr #(
        .BLEN_W(BLEN_W)
    ) u_beats (
        .clk   (clk),
        .rst   (rst),
        .load  (req_fire),
        .ld_len(plan_len),
        .beat  (beat),
        .last  (beat_last)
    );

    pgdma_steer #(
        .DATA_W(DATA_W)
    ) u_steer (
        .in_data        (state_q == MV_DATA),
        .dir            (dir_q),
        .fin_valid      (fin_valid),
        .fin_ready      (fin_ready),
        .fin_data       (fin_data),
        .mem_wdata_valid(mem_wdata_valid),
        .mem_wdata_ready(mem_wdata_ready),
        .mem_wdata      (mem_wdata),
        .mem_rdata_valid(mem_rdata_valid),
        .mem_rdata_ready(mem_rdata_ready),
        .mem_rdata      (mem_rdata),
        .fout_valid     (fout_valid),
        .fout_ready     (fout_ready),
        .fout_data      (fout_data),
        .beat           (beat)
    );
endmodule

// File: rtl/pgdma_mover_chk.sv
`timescale 1ns/1ps
module pgdma_mover_chk #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int PAGE_WORDS = 16,
    parameter int PCNT_W     = 8,
    parameter int BLEN_W     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [BLEN_W-1:0] cfg_burst_len,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_to_flash,
    input logic [ADDR_W-1:0] cmd_host_addr,
    input logic [PCNT_W-1:0] cmd_pages,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_rnw,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [BLEN_W-1:0] mem_req_len,
    input logic              mem_wdata_valid,
    input logic              mem_wdata_ready,
    input logic              mem_rdata_valid,
    input logic              mem_rdata_ready,
    input logic              fin_ready,
    input logic              fout_valid,
    input logic              xfer_done
);
    localparam int SH   = $clog2(DATA_W / 8);
    localparam int TW_W = PCNT_W + $clog2(PAGE_WORDS) + 1;

    logic              busy_q;
    logic              to_flash_q;
    logic [ADDR_W-1:0] exp_addr_q;
    logic [BLEN_W-1:0] blen_q;
    logic [TW_W-1:0]   words_q;
    logic [TW_W-1:0]   total_q;
    logic              taken;
    logic              moved;

    assign taken = cmd_valid && cmd_ready;
    assign moved = (mem_wdata_valid && mem_wdata_ready) || (mem_rdata_valid && mem_rdata_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            to_flash_q <= 1'b0;
            exp_addr_q <= '0;
            blen_q     <= BLEN_W'(1);
            words_q    <= '0;
            total_q    <= '0;
        end else begin
            if (taken) begin
                busy_q     <= 1'b1;
                to_flash_q <= cmd_to_flash;
                exp_addr_q <= cmd_host_addr;
                blen_q     <= (cfg_burst_len == '0) ? BLEN_W'(1) : cfg_burst_len;
                words_q    <= '0;
                total_q    <= TW_W'(cmd_pages) * TW_W'(PAGE_WORDS);
            end else begin
                if (xfer_done) busy_q <= 1'b0;
                if (mem_req_valid && mem_req_ready)
                    exp_addr_q <= exp_addr_q + (ADDR_W'(mem_req_len) << SH);
                if (moved) words_q <= words_q + TW_W'(1);
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> cmd_ready && !mem_req_valid && !xfer_done); // R8
    AST_WORDS_AT_DONE: assert property (@(posedge clk) disable iff (rst) xfer_done |-> words_q == total_q); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) xfer_done |=> !xfer_done); // R1
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst) mem_req_valid |-> mem_req_len != '0 && mem_req_len <= blen_q); // R2
    AST_ADDR_LINEAR: assert property (@(posedge clk) disable iff (rst) mem_req_valid |-> mem_req_addr == exp_addr_q); // R3
    AST_DIR_MATCH: assert property (@(posedge clk) disable iff (rst) mem_req_valid |-> mem_req_rnw == to_flash_q); // R4
    AST_OTHER_DIR_IDLE: assert property (@(posedge clk) disable iff (rst) busy_q && to_flash_q |-> !mem_wdata_valid && !fin_ready); // R4
    AST_OTHER_DIR_IDLE2: assert property (@(posedge clk) disable iff (rst) busy_q && !to_flash_q |-> !fout_valid && !mem_rdata_ready); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst) mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len)); // R5
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst) busy_q |-> !cmd_ready); // R6
    AST_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (rst) taken && cmd_pages == '0 |=> xfer_done && !mem_req_valid); // R7
endmodule

bind pgdma_mover pgdma_mover_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .PAGE_WORDS(PAGE_WORDS),
    .PCNT_W    (PCNT_W),
    .BLEN_W    (BLEN_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_burst_len  (cfg_burst_len),
    .cmd_valid      (cmd_valid),
    .cmd_ready      (cmd_ready),
    .cmd_to_flash   (cmd_to_flash),
    .cmd_host_addr  (cmd_host_addr),
    .cmd_pages      (cmd_pages),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_rnw    (mem_req_rnw),
    .mem_req_addr   (mem_req_addr),
    .mem_req_len    (mem_req_len),
    .mem_wdata_valid(mem_wdata_valid),
    .mem_wdata_ready(mem_wdata_ready),
    .mem_rdata_valid(mem_rdata_valid),
    .mem_rdata_ready(mem_rdata_ready),
    .fin_ready      (fin_ready),
    .fout_valid     (fout_valid),
    .xfer_done      (xfer_done)
);

// File: tb/pgdma_mover_tb.sv
`timescale 1ns/1ps
module pgdma_mover_tb;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;
    localparam int PW     = 16;
    localparam int PCNT_W = 8;
    localparam int BLEN_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [BLEN_W-1:0] cfg_burst_len = '0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic              cmd_to_flash = 1'b0;
    logic [ADDR_W-1:0] cmd_host_addr = '0;
    logic [PCNT_W-1:0] cmd_pages = '0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic              mem_req_rnw;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [BLEN_W-1:0] mem_req_len;
    logic              mem_wdata_valid;
    logic              mem_wdata_ready = 1'b0;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_rdata_valid = 1'b0;
    logic              mem_rdata_ready;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              fin_valid = 1'b0;
    logic              fin_ready;
    logic [DATA_W-1:0] fin_data = '0;
    logic              fout_valid;
    logic              fout_ready = 1'b0;
    logic [DATA_W-1:0] fout_data;
    logic              xfer_done;

    pgdma_mover #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_WORDS(PW), .PCNT_W(PCNT_W), .BLEN_W(BLEN_W)
    ) u_dut (
        .clk(clk), .rst(rst), .cfg_burst_len(cfg_burst_len),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_to_flash(cmd_to_flash),
        .cmd_host_addr(cmd_host_addr), .cmd_pages(cmd_pages),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_rnw(mem_req_rnw),
        .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
        .mem_wdata_valid(mem_wdata_valid), .mem_wdata_ready(mem_wdata_ready), .mem_wdata(mem_wdata),
        .mem_rdata_valid(mem_rdata_valid), .mem_rdata_ready(mem_rdata_ready), .mem_rdata(mem_rdata),
        .fin_valid(fin_valid), .fin_ready(fin_ready), .fin_data(fin_data),
        .fout_valid(fout_valid), .fout_ready(fout_ready), .fout_data(fout_data),
        .xfer_done(xfer_done)
    );

    always #4 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int ncyc = 0;
    int stall_pct = 0;
    int src_cnt = 0;
    int done_cnt = 0;
    int done_n = -1;
    int last_beat_n = -1;
    int accept_n = -1;
    bit finished = 0;
    logic [31:0] cur_seed = 32'h1;
    logic [31:0] got_addr[$];
    int          got_len[$];
    bit          got_rnw[$];
    logic [31:0] got_data[$];

    function automatic logic [31:0] pat(logic [31:0] seed, int i);
        return seed ^ (32'(i) * 32'h9E37_79B1);
    endfunction

    function automatic bit pass_now();
        return ($urandom % 100) >= stall_pct;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // environment: memory slave and flash stream models
    initial begin
        forever begin
            @(negedge clk);
            ncyc++;
            if (xfer_done) begin
                done_cnt++;
                done_n = ncyc;
            end
            mem_req_ready   = pass_now();
            mem_wdata_ready = pass_now();
            mem_rdata_valid = pass_now();
            fin_valid       = pass_now();
            fout_ready      = pass_now();
            fin_data        = pat(cur_seed, src_cnt);
            mem_rdata       = pat(cur_seed, src_cnt);
            #1;
            if (cmd_valid && cmd_ready) accept_n = ncyc;
            if (mem_req_valid && mem_req_ready) begin
                got_addr.push_back(mem_req_addr);
                got_len.push_back(int'(mem_req_len));
                got_rnw.push_back(mem_req_rnw);
            end
            if (mem_wdata_valid && mem_wdata_ready) begin
                got_data.push_back(mem_wdata);
                src_cnt++;
                last_beat_n = ncyc;
            end
            if (fout_valid && fout_ready) begin
                got_data.push_back(fout_data);
                src_cnt++;
                last_beat_n = ncyc;
            end
        end
    end

    task automatic run_cmd(int pages, int cfg, logic [31:0] addr, bit to_flash, int stall);
        logic [31:0] ea[$];
        int          el[$];
        int          total;
        int          b;
        int          rem;
        int          bad;
        int          guard;
        logic [31:0] a;
        stall_pct = stall;
        got_addr.delete(); got_len.delete(); got_rnw.delete(); got_data.delete();
        src_cnt = 0; done_cnt = 0; done_n = -1; last_beat_n = -1; accept_n = -1;
        cur_seed = $urandom;
        @(negedge clk);
        cfg_burst_len = BLEN_W'(cfg);
        cmd_pages     = PCNT_W'(pages);
        cmd_host_addr = addr;
        cmd_to_flash  = to_flash;
        cmd_valid     = 1'b1;
        #2;
        guard = 0;
        while (accept_n < 0 && guard < 50) begin
            @(negedge clk); #2; guard++;
        end
        // hold a foreign command and a moving burst setting during the transfer (R6, R2)
        guard = 0;
        while (done_cnt == 0 && guard < 20000) begin
            @(negedge clk); #2; guard++;
            if (done_cnt == 0) begin
                cmd_pages     = PCNT_W'($urandom);
                cmd_host_addr = $urandom;
                cmd_to_flash  = 1'($urandom);
                cfg_burst_len = BLEN_W'($urandom);
            end
        end
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);

        total = pages * PW;
        b = (cfg == 0) ? 1 : cfg;
        rem = total;
        a = addr;
        while (rem > 0) begin
            int l;
            l = (rem < b) ? rem : b;
            ea.push_back(a);
            el.push_back(l);
            a = a + 32'(l * (DATA_W / 8));
            rem = rem - l;
        end

        chk("R2", "burst count", got_addr.size(), ea.size());
        for (int i = 0; i < ea.size() && i < got_addr.size(); i++) begin
            chk("R3", $sformatf("burst %0d address", i), got_addr[i], ea[i]);
            chk("R2", $sformatf("burst %0d length", i), got_len[i], el[i]);
            chk("R4", $sformatf("burst %0d direction", i), got_rnw[i], to_flash);
        end
        chk("R1", "word count", got_data.size(), total);
        bad = 0;
        for (int i = 0; i < got_data.size(); i++)
            if (got_data[i] !== pat(cur_seed, i)) bad++;
        chk("R5", "words out of order or altered", bad, 0);
        chk("R6", "done pulses", done_cnt, 1);
        if (total > 0)
            chk("R1", "done cycle after last word", done_n, last_beat_n + 1);
        else
            chk("R7", "done cycle after accept", done_n, accept_n + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8", "cmd_ready in reset", cmd_ready, 1);
        chk("R8", "mem_req_valid in reset", mem_req_valid, 0);
        chk("R8", "xfer_done in reset", xfer_done, 0);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R8", "cmd_ready after reset", cmd_ready, 1);
        chk("R8", "fin_ready after reset", fin_ready, 0);
        chk("R8", "mem_rdata_ready after reset", mem_rdata_ready, 0);

        run_cmd(1, 16, 32'h0000_1000, 1'b0, 0);   // R1 whole page in one burst
        run_cmd(3, 5, 32'h0000_2000, 1'b1, 0);    // R2 short tail burst
        run_cmd(2, 0, 32'h0000_3004, 1'b0, 40);   // R2 zero setting means 1
        run_cmd(0, 4, 32'h0000_4000, 1'b1, 0);    // R7 empty command
        run_cmd(1, 200, 32'h0000_5000, 1'b1, 20); // R2 burst larger than transfer
        run_cmd(2, 8, 32'h0000_0FF0, 1'b0, 0);    // R3 crosses 4 KB unsplit
        run_cmd(4, 7, 32'h0001_0000, 1'b1, 75);   // R5 heavy stalls
        run_cmd(3, 1, 32'h0002_0000, 1'b0, 60);   // R5 single-word bursts
        void'($urandom(32'd1234));
        for (int k = 0; k < 24; k++)
            run_cmd(int'($urandom % 6), int'($urandom % 40),
                    $urandom & 32'hFFFF_FFFC, 1'($urandom), int'($urandom % 80));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule